// File: doc/BRIEF.md
# Palette DAC Loader Sequencer

This block holds a 256-entry colour palette, split into red, green and blue tables of one byte each, and loads it through two bus registers. Software first writes a start index to the index register and then streams colour bytes into the colour-map register. An internal phase counter steers each byte to the red, green or blue table of the current entry. After blue, the index steps forward. A colour-map write carries either one byte or one 32-bit word. A word is unpacked over four cycles, most significant byte first.

A scanout engine reads the palette through a separate combinational lookup port. It presents an 8-bit pixel and gets the 24-bit colour back in the same cycle. Every accepted colour-map write pulses a redraw request for one cycle, so the display path knows the whole frame must be repainted.

The bus side is a valid/ready request channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The requester keeps every request field stable until that edge. Ready is high at once for reads, index writes and single-byte colour-map writes. For a word colour-map write, ready stays low while the first three bytes are stored and rises in the cycle the fourth byte is stored. That is the back-pressure the requester sees.

Top module: `palette_loader`

## Requirements
- R1: A write with `req_addr`=0 (index register) loads `req_wdata[7:0]` as the current index and resets the component phase to red. `req_wdata[31:8]` are ignored.
- R2: Successive colour-map bytes go to red, then green, then blue of the current index. A partial entry keeps its untouched components.
- R3: Storing a blue byte increments the index modulo 256, so 255 wraps to 0, and returns the phase to red.
- R4: A word colour-map write (`req_addr`=1, `req_wide`=1) supplies four bytes in the order `req_wdata[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. Each byte advances the phase exactly as a single-byte write would.
- R5: A word colour-map write takes four cycles. `req_ready` is low during its first three cycles and high in the fourth. Reads, index writes and byte colour-map writes complete in one cycle.
- R6: A byte colour-map write (`req_addr`=1, `req_wide`=0) stores only `req_wdata[7:0]` as one component.
- R7: A read (`req_write`=0) of either register returns zero on `rsp_rdata` and changes neither the index nor the phase.
- R8: `redraw` is high for exactly the one cycle after each accepted colour-map write. It stays low after index writes and reads.
- R9: Reset clears every red, green and blue entry to zero, sets the index to 0 and sets the phase to red.
- R10: `lut_rgb` returns {red, green, blue} of entry `lut_pixel` (red in bits 23:16, blue in 7:0) in the same cycle, with no wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = index register, 1 = colour-map register |
| req_wide | input | 1 | 1 = 32-bit word, 0 = single byte |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, always zero |
| redraw | output | 1 | One-cycle full-redraw request |
| lut_pixel | input | 8 | Lookup pixel index |
| lut_rgb | output | 24 | Looked-up colour {R,G,B} |

## Verification
The bench builds the block with its default parameters: an 8-bit index, so 256 entries, 8-bit components and a 32-bit bus of four lanes. That depth makes the wrap from entry 255 to entry 0 reachable with a single index write. It also lets a word write start on entry 255 and finish on entry 0, so wrap and byte unpacking are checked together. The four-lane width lets a word write span an entry boundary at every phase offset, so a word that begins mid-entry is checked against the phase it inherits.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/pal_unpack.sv
module pal_unpack #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_act,
  input  logic              narrow_act,
  input  logic [BUS_W-1:0]  wdata,
  output logic              byte_vld,
  output logic [COMP_W-1:0] byte_data,
  output logic              wide_last
);
  localparam int unsigned LANES = BUS_W / COMP_W;
  localparam int unsigned CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LANES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [COMP_W-1:0] lanes [LANES];

  // lane 0 is the most significant byte
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = wdata[BUS_W-1-k*COMP_W -: COMP_W];
  end

  assign wide_last = (cnt == CNT_LAST);
  assign byte_vld  = wide_act | narrow_act;
  assign byte_data = wide_act ? lanes[cnt] : wdata[COMP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wide_act) begin
      cnt <= wide_last ? '0 : cnt + 1'b1;
    end
  end

  p_lane_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_act && !wide_last) |=> (cnt == $past(cnt) + 1'b1));

  p_lane_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_act && wide_last) |=> (cnt == '0));
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_ld,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             byte_vld,
  output logic [IDX_W-1:0] idx,
  output logic [NUM_COMP-1:0] comp_we
);
  phase_e phase;

  always_comb begin
    comp_we = '0;
    if (byte_vld) begin
      case (phase)
        PH_RED:  comp_we[2] = 1'b1;
        PH_GRN:  comp_we[1] = 1'b1;
        PH_BLU:  comp_we[0] = 1'b1;
        default: comp_we    = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (idx_ld) begin
      idx   <= idx_val;
      phase <= PH_RED;
    end else if (byte_vld) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd3) && $onehot0(comp_we));

  p_idx_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> (idx == $past(idx_val)) && (phase == PH_RED));

  p_idx_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !idx_ld && phase == PH_BLU) |=>
      (idx == $past(idx) + 1'b1) && (phase == PH_RED));

  p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !idx_ld) |=> $stable(idx) && $stable(phase));
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_COMP-1:0]        we,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [COMP_W-1:0]          wdata,
  input  logic [IDX_W-1:0]           raddr,
  output logic [NUM_COMP*COMP_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // component c: 2 = red, 1 = green, 0 = blue
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] tbl [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else if (we[c]) begin
        tbl[waddr] <= wdata;
      end
    end

    assign rdata[c*COMP_W +: COMP_W] = tbl[raddr];

    p_store_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we[c] && raddr == waddr) |=> (rdata[c*COMP_W +: COMP_W] == $past(wdata)) || (raddr != $past(raddr)));
  end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned BUS_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_addr,
  input  logic                       req_wide,
  input  logic [BUS_W-1:0]           req_wdata,
  output logic [BUS_W-1:0]           rsp_rdata,
  output logic                       redraw,
  input  logic [IDX_W-1:0]           lut_pixel,
  output logic [NUM_COMP*COMP_W-1:0] lut_rgb
);
  logic map_wr, wide_act, narrow_act, idx_ld;
  logic byte_vld, wide_last;
  logic [COMP_W-1:0] byte_data;
  logic [IDX_W-1:0] idx;
  logic [NUM_COMP-1:0] comp_we;

  assign map_wr     = req_valid & req_write & req_addr;
  assign wide_act   = map_wr & req_wide;
  assign narrow_act = map_wr & ~req_wide;
  assign idx_ld     = req_valid & req_write & ~req_addr;
  assign req_ready  = ~wide_act | wide_last;
  assign rsp_rdata  = '0;

  pal_unpack #(.BUS_W(BUS_W), .COMP_W(COMP_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .wide_act(wide_act), .narrow_act(narrow_act),
    .wdata(req_wdata), .byte_vld(byte_vld), .byte_data(byte_data),
    .wide_last(wide_last)
  );

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .idx_ld(idx_ld), .idx_val(req_wdata[IDX_W-1:0]),
    .byte_vld(byte_vld), .idx(idx), .comp_we(comp_we)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(comp_we), .waddr(idx), .wdata(byte_data),
    .raddr(lut_pixel), .rdata(lut_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) redraw <= 1'b0;
    else        redraw <= map_wr & req_ready;
  end

  p_redraw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_write && req_addr)) |=> !redraw);

  p_wide_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_act && !req_ready) |=> req_valid && req_wide);

  p_narrow_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_write && req_addr && req_wide)) |-> req_ready);
endmodule

// File: tb/test_palette_loader.sv
module test_palette_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0, req_wide = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  lut_pixel = '0;
  logic        req_ready, redraw;
  logic [31:0] rsp_rdata;
  logic [23:0] lut_rgb;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  palette_loader i_palette_loader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wide(req_wide),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .redraw(redraw),
    .lut_pixel(lut_pixel), .lut_rgb(lut_rgb)
  );

  // {sel, wide, data, pixel, expected rgb}
  localparam int NV = 14;
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_0010, 8'h10, 24'h000000},
    {1'b1, 1'b0, 32'h0000_00AA, 8'h10, 24'hAA0000},
    {1'b1, 1'b0, 32'h0000_00BB, 8'h10, 24'hAABB00},
    {1'b1, 1'b0, 32'h0000_00CC, 8'h10, 24'hAABBCC},
    {1'b1, 1'b1, 32'h1122_3344, 8'h11, 24'h112233},
    {1'b1, 1'b1, 32'h5566_7788, 8'h12, 24'h445566},
    {1'b1, 1'b0, 32'h0000_0099, 8'h13, 24'h778899},
    {1'b0, 1'b0, 32'h0000_00FF, 8'hFF, 24'h000000},
    {1'b1, 1'b1, 32'hA1B2_C3D4, 8'hFF, 24'hA1B2C3},
    {1'b1, 1'b0, 32'hFFFF_FFE5, 8'h00, 24'hD4E500},
    {1'b0, 1'b0, 32'h0000_0020, 8'h00, 24'hD4E500},
    {1'b1, 1'b0, 32'h0000_000F, 8'h20, 24'h0F0000},
    {1'b0, 1'b0, 32'hABCD_0130, 8'h30, 24'h000000},
    {1'b1, 1'b0, 32'h0000_0042, 8'h30, 24'h420000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic sel, input logic wide, input logic [31:0] d,
                    output int cyc, output logic rd, output logic [31:0] rdat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = sel; req_wide = wide; req_wdata = d;
    cyc = 1;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; cyc++;
    end
    rdat = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
    rd = redraw;
    @(posedge clk); #1;
    chk(redraw == 1'b0, "R8 pulse width", {31'd0, redraw}, 32'd0);
  endtask

  task automatic look(input logic [7:0] px, input logic [23:0] exp, input string req);
    lut_pixel = px; #1;
    chk(lut_rgb == exp, req, {8'd0, lut_rgb}, {8'd0, exp});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc; logic rd; logic [31:0] rdat;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    look(8'h00, 24'h0, "R9 reset entry 00");
    look(8'h7F, 24'h0, "R9 reset entry 7F");
    look(8'hFF, 24'h0, "R9 reset entry FF");
    chk(redraw == 1'b0, "R8 idle", {31'd0, redraw}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic sel, wide;
      sel = VEC[v][65]; wide = VEC[v][64];
      op(1'b1, sel, wide, VEC[v][63:32], cyc, rd, rdat);
      chk(cyc == (wide ? 4 : 1), "R5 cycles", cyc, wide ? 4 : 1);
      chk(rd == sel, "R8 redraw after write", {31'd0, rd}, {31'd0, sel});
      // R1 R2 R3 R4 R6 R10 lookup
      look(VEC[v][31:24], VEC[v][23:0], "R2/R4 lookup");
    end

    // R7: reads return zero and leave phase intact
    op(1'b1, 1'b0, 1'b0, 32'h40, cyc, rd, rdat);
    op(1'b1, 1'b1, 1'b0, 32'h01, cyc, rd, rdat);
    op(1'b0, 1'b1, 1'b0, 32'h5A, cyc, rd, rdat);
    chk(rdat == 32'h0, "R7 map read zero", rdat, 32'h0);
    chk(rd == 1'b0, "R8 no redraw on read", {31'd0, rd}, 32'd0);
    op(1'b0, 1'b0, 1'b1, 32'h5A, cyc, rd, rdat);
    chk(rdat == 32'h0, "R7 index read zero", rdat, 32'h0);
    chk(cyc == 1, "R5 read one cycle", cyc, 1);
    op(1'b1, 1'b1, 1'b0, 32'h02, cyc, rd, rdat);
    op(1'b1, 1'b1, 1'b0, 32'h03, cyc, rd, rdat);
    look(8'h40, 24'h010203, "R7 phase unchanged by read");
    look(8'h41, 24'h000000, "R3 next entry untouched");

    // R3 word write starting on phase green
    op(1'b1, 1'b0, 1'b0, 32'h50, cyc, rd, rdat);
    op(1'b1, 1'b1, 1'b0, 32'h11, cyc, rd, rdat);
    op(1'b1, 1'b1, 1'b1, 32'h2233_4455, cyc, rd, rdat);
    look(8'h50, 24'h112233, "R4 word mid-entry");
    look(8'h51, 24'h445500, "R4 word tail next index");

    // R9 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    look(8'h11, 24'h0, "R9 reset clears 11");
    look(8'h40, 24'h0, "R9 reset clears 40");
    op(1'b1, 1'b1, 1'b0, 32'h77, cyc, rd, rdat);
    look(8'h00, 24'h770000, "R9 index 0 phase red after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule